// File: doc/BRIEF.md
# Execution-Location Memory Space Mapper

This block places three on-chip memories into a Harvard arrangement: a 2k-word utility ROM, a 16k-word flash and a 256-word SRAM, each 16 bits wide. The memory that code is currently running from serves instruction fetches. The other two can be reached through the data address space. Which memories data space can reach therefore depends on where execution currently sits, and is not a fixed map.

A 2-bit code-region selector is loaded into a register together with the program counter. From the registered pair the block produces a one-hot fetch select and a local fetch address. At the same time it decodes a data address into a one-hot data select and a local data address. It also muxes the read words of the selected memories back onto an instruction bus and a data bus. A data access that hits the executing memory's own window, or that hits no window at all, returns zero and raises a fault flag for that cycle. The memory arrays live outside the block.

Top module: `memSpaceMapper`

## Requirements
- R1: While reset is active and right after it, the region is flash (code 00) and the program counter is 0. With `fetchEn` high, `fetchSel` is 3'b001 and `fetchAddr` is 0.
- R2: `pcIn` and `regionIn` are stored on a clock edge with `pcLoad` high. The new region governs fetch and data decoding from the next cycle, not from the cycle of the load.
- R3: Region codes are 00 flash, 01 SRAM, 10 ROM and 11 illegal. Select bit 0 is flash, bit 1 is SRAM and bit 2 is ROM. A legal fetch asserts the select bit of the region, drives `fetchAddr` with the program counter and returns that memory's word on `fetchWord`.
- R4: A fetch in region 11, or with a program counter at or above the region memory's size, asserts `fetchFault`, asserts no fetch select and returns a zero `fetchWord`.
- R5: The data windows are flash 0x0000–0x3FFF, SRAM 0x8000–0x80FF and ROM 0xC000–0xC7FF. `dataLocal` is the offset from the window base.
- R6: In the flash region, data accesses reach the SRAM and ROM windows.
- R7: In the SRAM region, data accesses reach the flash and ROM windows.
- R8: In the ROM region, data accesses reach the flash and SRAM windows.
- R9: A data access to the executing memory's window, or to an address outside every window, asserts `dataFault` in that cycle only. It asserts no data select and returns a zero `dataRdata`.
- R10: In region 11, every data access faults.
- R11: A fetch and a data access in the same cycle are decoded independently and never select the same memory.
- R12: With `fetchEn` and `dataEn` low, no select and no fault is asserted, and both returned words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pcLoad | input | 1 | Load program counter and region |
| pcIn | input | 16 | New program counter |
| regionIn | input | 2 | New code region code |
| fetchEn | input | 1 | Instruction fetch request |
| dataEn | input | 1 | Data access request |
| dataAddr | input | 16 | Data space word address |
| flashRdata | input | 16 | Flash read word |
| sramRdata | input | 16 | SRAM read word |
| romRdata | input | 16 | ROM read word |
| fetchSel | output | 3 | One-hot fetch memory select |
| fetchAddr | output | 14 | Local fetch address |
| fetchWord | output | 16 | Fetched instruction word |
| fetchFault | output | 1 | Illegal fetch |
| dataSel | output | 3 | One-hot data memory select |
| dataLocal | output | 14 | Local data address |
| dataRdata | output | 16 | Data read word |
| dataFault | output | 1 | Hidden or unmapped data access |

## Verification
A fetch and a data access can fall in the same cycle, each aimed at a different memory, and their returned words travel on separate buses. The bench sweeps data addresses across every window edge, with fetches enabled, in each of the four region codes. A behavioural model of the region and program counter predicts both paths on every clock. Each memory port in the bench follows whichever path selected it. A wrong word on either bus, or a select raised on both paths for one memory, shows up as a mismatch against the model.

// File: rtl/memMapPkg.sv
package memMapPkg;
  localparam int NUM_MEM = 3;

  typedef enum logic [1:0] {
    REG_FLASH = 2'd0,
    REG_SRAM  = 2'd1,
    REG_ROM   = 2'd2,
    REG_BAD   = 2'd3
  } region_e;

  typedef struct packed {
    logic [NUM_MEM-1:0] fetchSel;
    logic               fetchFault;
    logic [NUM_MEM-1:0] dataSel;
    logic               dataFault;
  } strobes_t;
endpackage

// File: rtl/memMapCtrl.sv
module memMapCtrl
  import memMapPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int FLASH_AW = 14,
  parameter int SRAM_AW = 8,
  parameter int ROM_AW = 11,
  parameter logic [ADDR_W-1:0] FLASH_BASE = 16'h0000,
  parameter logic [ADDR_W-1:0] SRAM_BASE = 16'h8000,
  parameter logic [ADDR_W-1:0] ROM_BASE = 16'hC000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pcLoad,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [1:0]        regionIn,
  input  logic              fetchEn,
  input  logic              dataEn,
  input  logic [ADDR_W-1:0] dataAddr,
  output logic [ADDR_W-1:0] pcQ,
  output strobes_t          strb
);
  localparam int MEM_AW [NUM_MEM] = '{FLASH_AW, SRAM_AW, ROM_AW};
  localparam logic [ADDR_W-1:0] MEM_BASE [NUM_MEM] = '{FLASH_BASE, SRAM_BASE, ROM_BASE};

  region_e regionQ;
  logic [NUM_MEM-1:0] fetchHit;
  logic [NUM_MEM-1:0] dataHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regionQ <= REG_FLASH;
      pcQ     <= '0;
    end else if (pcLoad) begin
      regionQ <= region_e'(regionIn);
      pcQ     <= pcIn;
    end
  end

  for (genvar g = 0; g < NUM_MEM; g++) begin : gMem
    logic isExec;
    logic pcInside;
    logic inWindow;
    assign isExec   = (regionQ == region_e'(2'(g)));
    assign pcInside = ((pcQ >> MEM_AW[g]) == '0);
    assign inWindow = ((dataAddr >> MEM_AW[g]) == (MEM_BASE[g] >> MEM_AW[g]));
    assign fetchHit[g] = fetchEn && isExec && pcInside;
    assign dataHit[g]  = dataEn && inWindow && !isExec && (regionQ != REG_BAD);
  end

  always_comb begin
    strb.fetchSel   = fetchHit;
    strb.fetchFault = fetchEn && (fetchHit == '0);
    strb.dataSel    = dataHit;
    strb.dataFault  = dataEn && (dataHit == '0);
  end
endmodule

// File: rtl/memMapPath.sv
module memMapPath
  import memMapPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LOCAL_AW = 14,
  parameter int FLASH_AW = 14,
  parameter int SRAM_AW = 8,
  parameter int ROM_AW = 11,
  parameter logic [ADDR_W-1:0] FLASH_BASE = 16'h0000,
  parameter logic [ADDR_W-1:0] SRAM_BASE = 16'h8000,
  parameter logic [ADDR_W-1:0] ROM_BASE = 16'hC000
) (
  input  logic [ADDR_W-1:0]   pcQ,
  input  logic [ADDR_W-1:0]   dataAddr,
  input  strobes_t            strb,
  input  logic [DATA_W-1:0]   flashRdata,
  input  logic [DATA_W-1:0]   sramRdata,
  input  logic [DATA_W-1:0]   romRdata,
  output logic [LOCAL_AW-1:0] fetchAddr,
  output logic [DATA_W-1:0]   fetchWord,
  output logic [LOCAL_AW-1:0] dataLocal,
  output logic [DATA_W-1:0]   dataRdata
);
  localparam logic [ADDR_W-1:0] MASK [NUM_MEM] = '{
    ADDR_W'((1 << FLASH_AW) - 1), ADDR_W'((1 << SRAM_AW) - 1), ADDR_W'((1 << ROM_AW) - 1)};
  localparam logic [ADDR_W-1:0] MEM_BASE [NUM_MEM] = '{FLASH_BASE, SRAM_BASE, ROM_BASE};

  logic [DATA_W-1:0] rdWord [NUM_MEM];
  assign rdWord[0] = flashRdata;
  assign rdWord[1] = sramRdata;
  assign rdWord[2] = romRdata;

  always_comb begin
    fetchAddr = '0;
    fetchWord = '0;
    dataLocal = '0;
    dataRdata = '0;
    for (int i = 0; i < NUM_MEM; i++) begin
      if (strb.fetchSel[i]) begin
        fetchAddr = LOCAL_AW'(pcQ & MASK[i]);
        fetchWord = rdWord[i];
      end
      if (strb.dataSel[i]) begin
        dataLocal = LOCAL_AW'((dataAddr - MEM_BASE[i]) & MASK[i]);
        dataRdata = rdWord[i];
      end
    end
  end
endmodule

// File: rtl/memSpaceMapper.sv
module memSpaceMapper
  import memMapPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int FLASH_AW = 14,
  parameter int SRAM_AW = 8,
  parameter int ROM_AW = 11,
  parameter logic [ADDR_W-1:0] FLASH_BASE = 16'h0000,
  parameter logic [ADDR_W-1:0] SRAM_BASE = 16'h8000,
  parameter logic [ADDR_W-1:0] ROM_BASE = 16'hC000,
  localparam int LOCAL_AW = (FLASH_AW > SRAM_AW)
                            ? ((FLASH_AW > ROM_AW) ? FLASH_AW : ROM_AW)
                            : ((SRAM_AW > ROM_AW) ? SRAM_AW : ROM_AW)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pcLoad,
  input  logic [ADDR_W-1:0]   pcIn,
  input  logic [1:0]          regionIn,
  input  logic                fetchEn,
  input  logic                dataEn,
  input  logic [ADDR_W-1:0]   dataAddr,
  input  logic [DATA_W-1:0]   flashRdata,
  input  logic [DATA_W-1:0]   sramRdata,
  input  logic [DATA_W-1:0]   romRdata,
  output logic [NUM_MEM-1:0]  fetchSel,
  output logic [LOCAL_AW-1:0] fetchAddr,
  output logic [DATA_W-1:0]   fetchWord,
  output logic                fetchFault,
  output logic [NUM_MEM-1:0]  dataSel,
  output logic [LOCAL_AW-1:0] dataLocal,
  output logic [DATA_W-1:0]   dataRdata,
  output logic                dataFault
);
  logic [ADDR_W-1:0] pcQ;
  strobes_t strb;

  memMapCtrl #(
    .ADDR_W(ADDR_W), .FLASH_AW(FLASH_AW), .SRAM_AW(SRAM_AW), .ROM_AW(ROM_AW),
    .FLASH_BASE(FLASH_BASE), .SRAM_BASE(SRAM_BASE), .ROM_BASE(ROM_BASE)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .pcLoad(pcLoad), .pcIn(pcIn), .regionIn(regionIn),
    .fetchEn(fetchEn), .dataEn(dataEn), .dataAddr(dataAddr), .pcQ(pcQ), .strb(strb)
  );

  memMapPath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCAL_AW(LOCAL_AW),
    .FLASH_AW(FLASH_AW), .SRAM_AW(SRAM_AW), .ROM_AW(ROM_AW),
    .FLASH_BASE(FLASH_BASE), .SRAM_BASE(SRAM_BASE), .ROM_BASE(ROM_BASE)
  ) i_path (
    .pcQ(pcQ), .dataAddr(dataAddr), .strb(strb),
    .flashRdata(flashRdata), .sramRdata(sramRdata), .romRdata(romRdata),
    .fetchAddr(fetchAddr), .fetchWord(fetchWord), .dataLocal(dataLocal), .dataRdata(dataRdata)
  );

  assign fetchSel   = strb.fetchSel;
  assign fetchFault = strb.fetchFault;
  assign dataSel    = strb.dataSel;
  assign dataFault  = strb.dataFault;
endmodule

// File: rtl/memSpaceMapperChk.sv
module memSpaceMapperChk (
  input logic        clk,
  input logic        rstN,
  input logic        pcLoad,
  input logic [15:0] pcIn,
  input logic [1:0]  regionIn,
  input logic        fetchEn,
  input logic        dataEn,
  input logic [2:0]  fetchSel,
  input logic        fetchFault,
  input logic [2:0]  dataSel,
  input logic [15:0] dataRdata,
  input logic [15:0] fetchWord,
  input logic        dataFault
);
  // R3
  fetch_onehot_chk: assert property (@(posedge clk) disable iff (!rstN) $onehot0(fetchSel));
  // R5
  data_onehot_chk: assert property (@(posedge clk) disable iff (!rstN) $onehot0(dataSel));
  // R11
  no_shared_mem_chk: assert property (@(posedge clk) disable iff (!rstN) (fetchSel & dataSel) == 3'b000);
  // R9
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataFault |-> (dataSel == 3'b000 && dataRdata == 16'h0000));
  // R4
  fetch_fault_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchFault |-> (fetchSel == 3'b000 && fetchWord == 16'h0000));
  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!fetchEn && !dataEn) |-> (fetchSel == 3'b000 && dataSel == 3'b000 && !fetchFault && !dataFault));
  // R2
  region_switch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pcLoad && regionIn != 2'b11 && pcIn == 16'h0000)
      |=> (!fetchEn || fetchSel == (3'b001 << $past(regionIn))));
endmodule

bind memSpaceMapper memSpaceMapperChk i_chk (
  .clk(clk), .rstN(rstN), .pcLoad(pcLoad), .pcIn(pcIn), .regionIn(regionIn),
  .fetchEn(fetchEn), .dataEn(dataEn), .fetchSel(fetchSel), .fetchFault(fetchFault),
  .dataSel(dataSel), .dataRdata(dataRdata), .fetchWord(fetchWord), .dataFault(dataFault)
);

// File: tb/test_memSpaceMapper.sv
module test_memSpaceMapper;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pcLoad = 1'b0;
  logic [15:0] pcIn = '0;
  logic [1:0] regionIn = '0;
  logic fetchEn = 1'b0;
  logic dataEn = 1'b0;
  logic [15:0] dataAddr = '0;
  logic [15:0] flashRdata, sramRdata, romRdata;
  logic [2:0] fetchSel, dataSel;
  logic [13:0] fetchAddr, dataLocal;
  logic [15:0] fetchWord, dataRdata;
  logic fetchFault, dataFault;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int mReg = 0;
  int mPc = 0;

  always #4 clk = ~clk;

  memSpaceMapper i_memSpaceMapper (
    .clk(clk), .rstN(rstN), .pcLoad(pcLoad), .pcIn(pcIn), .regionIn(regionIn),
    .fetchEn(fetchEn), .dataEn(dataEn), .dataAddr(dataAddr),
    .flashRdata(flashRdata), .sramRdata(sramRdata), .romRdata(romRdata),
    .fetchSel(fetchSel), .fetchAddr(fetchAddr), .fetchWord(fetchWord), .fetchFault(fetchFault),
    .dataSel(dataSel), .dataLocal(dataLocal), .dataRdata(dataRdata), .dataFault(dataFault)
  );

  function automatic logic [15:0] memWord(int m, int a);
    case (m)
      0: return 16'hF000 ^ 16'(a);
      1: return 16'h5A00 ^ 16'(a);
      default: return 16'hC300 ^ 16'(a);
    endcase
  endfunction

  // Memory models: each port follows the path that selected it
  assign flashRdata = memWord(0, int'(fetchSel[0] ? fetchAddr : dataLocal));
  assign sramRdata  = memWord(1, int'(fetchSel[1] ? fetchAddr : dataLocal));
  assign romRdata   = memWord(2, int'(fetchSel[2] ? fetchAddr : dataLocal));

  function automatic int memSize(int m);
    case (m)
      0: return 16384;
      1: return 256;
      default: return 2048;
    endcase
  endfunction

  task automatic runCyc(input logic pl, input int pi, input int ri, input logic fe,
                        input logic de, input int da, input string req);
    logic [2:0] eFs, eDs;
    logic [13:0] eFa, eDl;
    logic [15:0] eFw, eDr;
    logic eFf, eDf;
    int win, off;
    pcLoad = pl; pcIn = 16'(pi); regionIn = 2'(ri);
    fetchEn = fe; dataEn = de; dataAddr = 16'(da);
    #3;
    eFs = '0; eFa = '0; eFw = '0; eFf = 1'b0;
    if (fe) begin
      if (mReg != 3 && mPc < memSize(mReg)) begin
        eFs = 3'(1 << mReg); eFa = 14'(mPc); eFw = memWord(mReg, mPc);
      end else eFf = 1'b1;
    end
    win = -1; off = 0;
    if (da < 16'h4000) begin win = 0; off = da; end
    else if (da >= 16'h8000 && da < 16'h8100) begin win = 1; off = da - 16'h8000; end
    else if (da >= 16'hC000 && da < 16'hC800) begin win = 2; off = da - 16'hC000; end
    eDs = '0; eDl = '0; eDr = '0; eDf = 1'b0;
    if (de) begin
      if (win >= 0 && win != mReg && mReg != 3) begin
        eDs = 3'(1 << win); eDl = 14'(off); eDr = memWord(win, off);
      end else eDf = 1'b1;
    end
    checks++;
    if ({fetchSel, fetchAddr, fetchWord, fetchFault, dataSel, dataLocal, dataRdata, dataFault} !==
        {eFs, eFa, eFw, eFf, eDs, eDl, eDr, eDf}) begin
      errors++;
      $display("FAIL %s: got fs=%b fa=%h fw=%h ff=%b ds=%b dl=%h dr=%h df=%b exp fs=%b fa=%h fw=%h ff=%b ds=%b dl=%h dr=%h df=%b",
               req, fetchSel, fetchAddr, fetchWord, fetchFault, dataSel, dataLocal, dataRdata, dataFault,
               eFs, eFa, eFw, eFf, eDs, eDl, eDr, eDf);
    end
    @(posedge clk);
    if (!rstN) begin mReg = 0; mPc = 0; end
    else if (pl) begin mReg = ri; mPc = pi; end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int addrs [10] = '{16'h0000, 16'h3FFF, 16'h4000, 16'h8000, 16'h80FF,
                       16'h8100, 16'hC000, 16'hC7FF, 16'hC800, 16'hFFFF};
    string tag;
    @(negedge clk);
    // R1: reset state
    runCyc(1'b0, 0, 0, 1'b1, 1'b0, 0, "R1");
    runCyc(1'b1, 16'h0100, 1, 1'b1, 1'b0, 0, "R1");
    rstN = 1'b1;
    runCyc(1'b0, 0, 0, 1'b1, 1'b0, 0, "R1");
    // R3: legal fetches per region; R2: load takes effect next cycle
    runCyc(1'b1, 16'h0123, 0, 1'b1, 1'b0, 0, "R2");
    runCyc(1'b1, 16'h0042, 1, 1'b1, 1'b0, 0, "R3");
    runCyc(1'b1, 16'h07FF, 2, 1'b1, 1'b1, 16'h80FF, "R2");
    runCyc(1'b1, 16'h3FFF, 0, 1'b1, 1'b1, 16'h0005, "R3");
    runCyc(1'b0, 0, 0, 1'b1, 1'b1, 16'h0005, "R9");
    // R4: fetch out of range or illegal region
    runCyc(1'b1, 16'h0800, 2, 1'b1, 1'b0, 0, "R3");
    runCyc(1'b1, 16'h0100, 1, 1'b1, 1'b0, 0, "R4");
    runCyc(1'b1, 16'h0000, 3, 1'b1, 1'b0, 0, "R4");
    runCyc(1'b1, 16'h4000, 0, 1'b1, 1'b0, 0, "R4");
    runCyc(1'b1, 16'h0010, 0, 1'b1, 1'b0, 0, "R4");
    // R6 R7 R8 R9 R10 R11: sweep data windows with concurrent fetch
    for (int r = 0; r < 4; r++) begin
      runCyc(1'b1, 16'h0007, r, 1'b0, 1'b0, 0, "R2");
      foreach (addrs[k]) begin
        case (r)
          0: tag = "R6";
          1: tag = "R7";
          2: tag = "R8";
          default: tag = "R10";
        endcase
        runCyc(1'b0, 0, 0, 1'b1, 1'b1, addrs[k], tag);
        runCyc(1'b0, 0, 0, 1'b0, 1'b1, addrs[k], "R9");
      end
    end
    // R5: window offsets at edges
    runCyc(1'b1, 16'h0001, 2, 1'b0, 1'b1, 16'h3FFF, "R5");
    runCyc(1'b0, 0, 0, 1'b0, 1'b1, 16'h3FFF, "R5");
    runCyc(1'b0, 0, 0, 1'b0, 1'b1, 16'h80FF, "R5");
    runCyc(1'b1, 16'h0002, 0, 1'b0, 1'b1, 16'h80AB, "R5");
    runCyc(1'b0, 0, 0, 1'b0, 1'b1, 16'hC7FF, "R5");
    // R11: fetch and data in the same cycle
    runCyc(1'b1, 16'h0033, 1, 1'b1, 1'b1, 16'hC123, "R11");
    runCyc(1'b0, 0, 0, 1'b1, 1'b1, 16'h1234, "R11");
    runCyc(1'b0, 0, 0, 1'b1, 1'b1, 16'hC456, "R11");
    // R9: fault lasts one cycle
    runCyc(1'b0, 0, 0, 1'b1, 1'b1, 16'h8001, "R9");
    runCyc(1'b0, 0, 0, 1'b1, 1'b1, 16'h0001, "R9");
    // R12: idle
    runCyc(1'b0, 0, 0, 1'b0, 1'b0, 16'h8001, "R12");
    runCyc(1'b0, 0, 0, 1'b0, 1'b0, 16'hC000, "R12");
    runCyc(1'b1, 16'h0000, 3, 1'b0, 1'b0, 16'h5000, "R12");
    runCyc(1'b0, 0, 0, 1'b0, 1'b0, 16'h5000, "R12");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule